// File: doc/BRIEF.md
# Shared-SRAM Multi-Queue Manager

This block keeps 64 independent FIFO queues as circular buffers inside a single 2048-word by 32-bit on-chip SRAM. Software places each queue by writing a configuration word holding its base word address, its buffer size, its entry size, two thresholds, an interrupt enable and an interrupt source select. From then on the block owns the write pointer, read pointer, fill count and sticky error bits of every queue. Producers push a word by writing to a queue's data address. Consumers pop a word by reading that same address.

All traffic uses one memory-mapped slave port with a valid/ready request and a one-cycle-later read response. The 13-bit word address is split as follows:
- `bus_addr[12:11]` = 00 is the queue data window. `bus_addr[5:0]` picks the queue.
- 01 is the queue register window. `bus_addr[6]` = 0 is the configuration word and 1 is the status word. `bus_addr[5:0]` picks the queue.
- 10 is a direct window onto SRAM word `bus_addr[10:0]`.
- 11 reads as zero and ignores writes.

Queue status leaves the block in three forms. Queues 0 to 31 each drive one bit of `flag_lo`. Queues 32 to 63 are merged into the single `evt_hi`. One interrupt line serves each half. A controller state machine sequences the port through three states:
- `ST_IDLE` accepts requests. A write completes in the accepting cycle and stays in `ST_IDLE`.
- A read that needs the SRAM (a pop of a non-empty queue, or a direct read) moves to `ST_MEMRD`.
- Any other read (a register read, a pop of an empty queue, or a read of the unused window) moves to `ST_REGRD`.
- Both response states return to `ST_IDLE` unconditionally after one cycle.

Top module: `qm_top`

## Requirements
- R1: After reset every queue is empty. `flag_lo`, `evt_hi`, `irq_lo` and `irq_hi` are 0, and the status word of any queue reads 0x00000003.
- R2: Words popped from a queue come out in push order. The pointers wrap from base+size-1 back to base, so the word pushed after the wrap lands at SRAM word `base`.
- R3: A push to a full queue leaves its contents and count unchanged and sets that queue's overflow bit.
- R4: A pop from an empty queue returns 0 and sets that queue's underflow bit.
- R5: A status read returns the overflow and underflow bits and then clears them.
- R6: The status word is laid out as follows. Bit 0 is empty and bit 3 is full. Bits 15:8 hold the fill count in words.
  - Bit 1 is nearly-empty: entries held is at most the nearly-empty threshold.
  - Bit 2 is nearly-full: free entries is at most the nearly-full threshold.
  - Bit 4 is overflow and bit 5 is underflow.
  - Entries are counted as words shifted right by 0, 1 or 2 for entry-size codes 0, 1, 2 (3 acts as 2).
- R7: The configuration word is laid out as follows, and reads back as written.
  - Base is bits 10:0.
  - The size code is bits 12:11, giving 16 << code words.
  - The entry-size code is bits 14:13.
  - The nearly-empty threshold is bits 21:15 and the nearly-full threshold is bits 28:22.
  - The interrupt enable is bit 29 and the source select is bits 31:30.
  - Writing the configuration word empties the queue and clears its sticky bits.
- R8: The direct SRAM window reads and writes the same words that the queues use.
- R9: `flag_lo[i]` is the selected condition of queue i. Source select 0 is not-empty, 1 is nearly-full, 2 is full and 3 is nearly-empty.
- R10: `evt_hi` is the OR of the selected conditions of queues 32 to 63.
- R11: `irq_lo` and `irq_hi` are each the OR, over their half, of the selected conditions whose interrupt enable is set.
- R12: `bus_ready` is high only in `ST_IDLE`. A read accepted in one cycle gives `bus_rvalid` with its data in the next cycle. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted this cycle when valid |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| flag_lo | output | 32 | Selected condition of queues 0 to 31 |
| evt_hi | output | 1 | Combined condition of queues 32 to 63 |
| irq_lo | output | 1 | Interrupt for queues 0 to 31 |
| irq_hi | output | 1 | Interrupt for queues 32 to 63 |

## Verification
The hardest situation to reach is a wrapped buffer that is full again after being partly drained. In that state both pointers sit mid-buffer, and the write pointer has already passed the top once. The stimulus fills a 16-word queue, tries one push too many, and pops five words. It then pushes five more words so that they land at the base. Finally it drains all sixteen words and checks both the order and the SRAM word at the base through the direct window. A four-word-entry queue is filled across both threshold crossings, so the entry-scaled flags are exercised away from their trivial values.

// File: rtl/qm_pkg.sv
package qm_pkg;
    localparam int MEM_AW  = 11;
    localparam int THR_W   = 7;
    localparam int PTR_W   = 7;
    localparam int CNT_W   = PTR_W + 1;
    localparam int MIN_BUF = 16;

    typedef struct packed {
        logic [1:0]        src;
        logic              ien;
        logic [THR_W-1:0]  nf_thr;
        logic [THR_W-1:0]  ne_thr;
        logic [1:0]        esz;
        logic [1:0]        bsz;
        logic [MEM_AW-1:0] base;
    } qcfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MEMRD = 2'd1,
        ST_REGRD = 2'd2
    } qm_state_e;

    typedef enum logic [1:0] {
        SRC_NOT_EMPTY  = 2'd0,
        SRC_NEAR_FULL  = 2'd1,
        SRC_FULL       = 2'd2,
        SRC_NEAR_EMPTY = 2'd3
    } qm_src_e;

    typedef enum logic [1:0] {
        RGN_QUEUE = 2'd0,
        RGN_REGS  = 2'd1,
        RGN_RAW   = 2'd2,
        RGN_NONE  = 2'd3
    } qm_rgn_e;
endpackage

// File: rtl/qm_sram.sv
module qm_sram #(
    parameter int DEPTH = 2048,
    parameter int DW    = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/qm_qstate.sv
module qm_qstate
    import qm_pkg::*;
#(
    parameter int NUM_Q = 64,
    parameter int QW    = $clog2(NUM_Q)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic                        push,
    input  logic                        pop,
    input  logic                        clr_sticky,
    input  logic [QW-1:0]               qsel,
    input  qcfg_t                       cfg_wdata,
    output qcfg_t [NUM_Q-1:0]           cfg_o,
    output logic [NUM_Q-1:0][CNT_W-1:0] cnt_o,
    output logic [NUM_Q-1:0]            ovf_o,
    output logic [NUM_Q-1:0]            unf_o,
    output logic [MEM_AW-1:0]           wr_addr,
    output logic [MEM_AW-1:0]           rd_addr,
    output logic                        full_sel,
    output logic                        empty_sel,
    output logic [CNT_W-1:0]            cnt_sel,
    output logic [CNT_W-1:0]            size_sel
);
    qcfg_t [NUM_Q-1:0]           cfg_q;
    logic  [NUM_Q-1:0][PTR_W-1:0] wptr_q, rptr_q;
    logic  [NUM_Q-1:0][CNT_W-1:0] cnt_q;
    logic  [NUM_Q-1:0]            ovf_q, unf_q;
    logic  [PTR_W-1:0]            mask_sel;

    always_comb begin
        size_sel  = CNT_W'(MIN_BUF) << cfg_q[qsel].bsz;
        mask_sel  = size_sel[PTR_W-1:0] - PTR_W'(1);
        cnt_sel   = cnt_q[qsel];
        full_sel  = (cnt_sel == size_sel);
        empty_sel = (cnt_sel == '0);
        wr_addr   = cfg_q[qsel].base + MEM_AW'(wptr_q[qsel]);
        rd_addr   = cfg_q[qsel].base + MEM_AW'(rptr_q[qsel]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= '0;
            unf_q  <= '0;
        end else if (cfg_we) begin
            cfg_q[qsel]  <= cfg_wdata;
            wptr_q[qsel] <= '0;
            rptr_q[qsel] <= '0;
            cnt_q[qsel]  <= '0;
            ovf_q[qsel]  <= 1'b0;
            unf_q[qsel]  <= 1'b0;
        end else if (push) begin
            if (full_sel) begin
                ovf_q[qsel] <= 1'b1;
            end else begin
                wptr_q[qsel] <= (wptr_q[qsel] + PTR_W'(1)) & mask_sel;
                cnt_q[qsel]  <= cnt_sel + CNT_W'(1);
            end
        end else if (pop) begin
            if (empty_sel) begin
                unf_q[qsel] <= 1'b1;
            end else begin
                rptr_q[qsel] <= (rptr_q[qsel] + PTR_W'(1)) & mask_sel;
                cnt_q[qsel]  <= cnt_sel - CNT_W'(1);
            end
        end else if (clr_sticky) begin
            ovf_q[qsel] <= 1'b0;
            unf_q[qsel] <= 1'b0;
        end
    end

    assign cfg_o = cfg_q;
    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;
    assign unf_o = unf_q;
endmodule

// File: rtl/qm_status.sv
module qm_status
    import qm_pkg::*;
#(
    parameter int NUM_Q = 64
) (
    input  qcfg_t [NUM_Q-1:0]           cfg_i,
    input  logic  [NUM_Q-1:0][CNT_W-1:0] cnt_i,
    output logic  [NUM_Q-1:0][3:0]       flags_o,
    output logic  [NUM_Q-1:0]            cond_o,
    output logic  [NUM_Q-1:0]            irq_o
);
    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        logic [CNT_W-1:0] size_w, ent, free_ent;
        logic [1:0]       shamt;
        logic             empty, full, near_e, near_f;

        always_comb begin
            size_w   = CNT_W'(MIN_BUF) << cfg_i[g].bsz;
            shamt    = (cfg_i[g].esz == 2'd3) ? 2'd2 : cfg_i[g].esz;
            ent      = cnt_i[g] >> shamt;
            free_ent = (size_w - cnt_i[g]) >> shamt;
            empty    = (cnt_i[g] == '0);
            full     = (cnt_i[g] == size_w);
            near_e   = (ent <= CNT_W'(cfg_i[g].ne_thr));
            near_f   = (free_ent <= CNT_W'(cfg_i[g].nf_thr));
            unique case (qm_src_e'(cfg_i[g].src))
                SRC_NOT_EMPTY:  cond_o[g] = !empty;
                SRC_NEAR_FULL:  cond_o[g] = near_f;
                SRC_FULL:       cond_o[g] = full;
                SRC_NEAR_EMPTY: cond_o[g] = near_e;
                default:        cond_o[g] = 1'b0;
            endcase
            irq_o[g]   = cond_o[g] & cfg_i[g].ien;
            flags_o[g] = {full, near_f, near_e, empty};
        end
    end
endmodule

// File: rtl/qm_top.sv
module qm_top
    import qm_pkg::*;
#(
    parameter int NUM_Q     = 64,
    parameter int MEM_WORDS = 2048,
    parameter int DW        = 32,
    parameter int BUS_AW    = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic               bus_ready,
    output logic               bus_rvalid,
    output logic [DW-1:0]      bus_rdata,
    output logic [NUM_Q/2-1:0] flag_lo,
    output logic               evt_hi,
    output logic               irq_lo,
    output logic               irq_hi
);
    localparam int QW   = $clog2(NUM_Q);
    localparam int HALF = NUM_Q / 2;

    qm_state_e state_q, state_n;
    qm_rgn_e   rgn;
    logic [QW-1:0] qid;
    logic acc, push, pop, cfg_we, clr_sticky, stat_sel;
    logic mem_we, mem_re, pop_empty;
    logic [MEM_AW-1:0] mem_addr, wr_addr, rd_addr;
    logic [DW-1:0] mem_q, resp_q, resp_n, stat_word;
    logic full_sel, empty_sel;
    logic [CNT_W-1:0] sel_cnt, sel_size;

    qcfg_t [NUM_Q-1:0]           cfg_v;
    logic  [NUM_Q-1:0][CNT_W-1:0] cnt_v;
    logic  [NUM_Q-1:0]            ovf_v, unf_v, cond_v, irq_v;
    logic  [NUM_Q-1:0][3:0]       flags_v;

    // request decode
    always_comb begin
        rgn        = qm_rgn_e'(bus_addr[BUS_AW-1:BUS_AW-2]);
        qid        = bus_addr[QW-1:0];
        stat_sel   = bus_addr[QW];
        acc        = bus_valid && (state_q == ST_IDLE);
        push       = acc &&  bus_write && (rgn == RGN_QUEUE);
        pop        = acc && !bus_write && (rgn == RGN_QUEUE);
        cfg_we     = acc &&  bus_write && (rgn == RGN_REGS) && !stat_sel;
        clr_sticky = acc && !bus_write && (rgn == RGN_REGS) && stat_sel;
        pop_empty  = pop && empty_sel;
        mem_we     = (push && !full_sel) || (acc && bus_write && (rgn == RGN_RAW));
        mem_re     = (pop && !empty_sel) || (acc && !bus_write && (rgn == RGN_RAW));
        if (push) begin
            mem_addr = wr_addr;
        end else if (pop) begin
            mem_addr = rd_addr;
        end else begin
            mem_addr = bus_addr[MEM_AW-1:0];
        end
    end

    qm_sram #(.DEPTH(MEM_WORDS), .DW(DW), .AW(MEM_AW)) u_sram (
        .clk  (clk),
        .we   (mem_we),
        .re   (mem_re),
        .addr (mem_addr),
        .wdata(bus_wdata),
        .rdata(mem_q)
    );

    qm_qstate #(.NUM_Q(NUM_Q), .QW(QW)) u_qstate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .push      (push),
        .pop       (pop),
        .clr_sticky(clr_sticky),
        .qsel      (qid),
        .cfg_wdata (qcfg_t'(bus_wdata)),
        .cfg_o     (cfg_v),
        .cnt_o     (cnt_v),
        .ovf_o     (ovf_v),
        .unf_o     (unf_v),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .full_sel  (full_sel),
        .empty_sel (empty_sel),
        .cnt_sel   (sel_cnt),
        .size_sel  (sel_size)
    );

    qm_status #(.NUM_Q(NUM_Q)) u_status (
        .cfg_i  (cfg_v),
        .cnt_i  (cnt_v),
        .flags_o(flags_v),
        .cond_o (cond_v),
        .irq_o  (irq_v)
    );

    assign flag_lo = cond_v[HALF-1:0];
    assign evt_hi  = |cond_v[NUM_Q-1:HALF];
    assign irq_lo  = |irq_v[HALF-1:0];
    assign irq_hi  = |irq_v[NUM_Q-1:HALF];

    // register read data and next state
    always_comb begin
        stat_word = {16'b0, sel_cnt, 2'b00, unf_v[qid], ovf_v[qid], flags_v[qid]};
        resp_n    = '0;
        if (rgn == RGN_REGS) begin
            resp_n = stat_sel ? stat_word : DW'(cfg_v[qid]);
        end
        state_n = ST_IDLE;
        if (acc && !bus_write) begin
            state_n = mem_re ? ST_MEMRD : ST_REGRD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else if (acc && !bus_write) begin
            resp_q <= resp_n;
        end
    end

    // port outputs per state
    always_comb begin
        bus_ready  = 1'b0;
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        unique case (state_q)
            ST_IDLE:  bus_ready = 1'b1;
            ST_MEMRD: begin
                bus_rvalid = 1'b1;
                bus_rdata  = mem_q;
            end
            ST_REGRD: begin
                bus_rvalid = 1'b1;
                bus_rdata  = resp_q;
            end
            default: bus_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/qm_top_chk.sv
module qm_top_chk #(
    parameter int NUM_Q = 64,
    parameter int DW    = 32,
    parameter int CW    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_write,
    input logic               bus_ready,
    input logic               bus_rvalid,
    input logic [DW-1:0]      bus_rdata,
    input logic [NUM_Q/2-1:0] flag_lo,
    input logic               evt_hi,
    input logic               irq_lo,
    input logic               irq_hi,
    input logic               pop_empty,
    input logic [CW-1:0]      sel_cnt,
    input logic [CW-1:0]      sel_size
);
    // R12
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && !bus_write) |=> bus_rvalid);

    // R12
    write_noresp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_write) |=> !bus_rvalid);

    // R12
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> !bus_ready);

    // R4
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_empty |=> (bus_rvalid && bus_rdata == '0));

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_cnt <= sel_size);

    // R11
    irq_lo_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (flag_lo != '0));

    // R10
    irq_hi_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> evt_hi);
endmodule

bind qm_top qm_top_chk #(.NUM_Q(NUM_Q), .DW(DW), .CW(qm_pkg::CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_ready (bus_ready),
    .bus_rvalid(bus_rvalid),
    .bus_rdata (bus_rdata),
    .flag_lo   (flag_lo),
    .evt_hi    (evt_hi),
    .irq_lo    (irq_lo),
    .irq_hi    (irq_hi),
    .pop_empty (pop_empty),
    .sel_cnt   (sel_cnt),
    .sel_size  (sel_size)
);

// File: tb/qm_top_tb_top.sv
module qm_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid, evt_hi, irq_lo, irq_hi;
    logic [31:0] bus_rdata, flag_lo;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    qm_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .flag_lo(flag_lo),
        .evt_hi(evt_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    typedef struct packed {
        logic        wr;
        logic [12:0] addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam logic [31:0] CFG0 = {2'd1, 1'b1, 7'd2, 7'd1, 2'd0, 2'd0, 11'h000};

    localparam vec_t VECS [13] = '{
        '{1'b1, 13'h0800, CFG0,         8'd7},  // R7 configure queue 0
        '{1'b0, 13'h0840, 32'h00000003, 8'd6},  // R6 empty status
        '{1'b1, 13'h0000, 32'h000000A1, 8'd2},  // R2 push
        '{1'b1, 13'h0000, 32'h000000A2, 8'd2},  // R2 push
        '{1'b0, 13'h0840, 32'h00000200, 8'd6},  // R6 two words held
        '{1'b0, 13'h0000, 32'h000000A1, 8'd2},  // R2 order
        '{1'b0, 13'h0000, 32'h000000A2, 8'd2},  // R2 order
        '{1'b0, 13'h0840, 32'h00000003, 8'd6},  // R6 empty again
        '{1'b0, 13'h0800, CFG0,         8'd7},  // R7 readback
        '{1'b1, 13'h0000, 32'h000000B3, 8'd8},  // R8 push at offset 2
        '{1'b0, 13'h1002, 32'h000000B3, 8'd8},  // R8 direct read
        '{1'b1, 13'h1002, 32'h000000C4, 8'd8},  // R8 direct write
        '{1'b0, 13'h0000, 32'h000000C4, 8'd8}   // R8 pop sees direct write
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [12:0] a, input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        rd = bus_rdata;
        chk(bus_rvalid == !wr, "R12", {31'b0, bus_rvalid}, {31'b0, !wr});
    endtask

    task automatic wr_op(input logic [12:0] a, input logic [31:0] d);
        logic [31:0] unused;
        bus_op(1'b1, a, d, unused);
    endtask

    task automatic rd_exp(input logic [12:0] a, input logic [31:0] exp, input string req);
        logic [31:0] got;
        bus_op(1'b0, a, 32'h0, got);
        chk(got == exp, req, got, exp);
    endtask

    function automatic logic [31:0] mkcfg(input logic [1:0] src, input logic en, input logic [6:0] nf,
                                          input logic [6:0] ne, input logic [1:0] esz, input logic [1:0] bsz,
                                          input logic [10:0] base);
        return {src, en, nf, ne, esz, bsz, base};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R12 watchdog act=%h exp=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(bus_ready == 1'b1 && bus_rvalid == 1'b0, "R1", {30'b0, bus_ready, bus_rvalid}, 32'h2);
        chk(flag_lo == 32'h0, "R1", flag_lo, 32'h0);
        chk({evt_hi, irq_lo, irq_hi} == 3'b000, "R1", {29'b0, evt_hi, irq_lo, irq_hi}, 32'h0);
        rd_exp(13'h0845, 32'h00000003, "R1");

        // table walk
        foreach (VECS[i]) begin
            if (VECS[i].wr) begin
                wr_op(VECS[i].addr, VECS[i].data);
            end else begin
                bus_op(1'b0, VECS[i].addr, 32'h0, got);
                total++;
                if (got != VECS[i].data) begin
                    bad++;
                    $display("FAIL R%0d row %0d act=%h exp=%h", VECS[i].req, i, got, VECS[i].data);
                end
            end
        end

        // R2 R3 R5: fill, overflow, wrap
        wr_op(13'h0801, mkcfg(2'd0, 1'b0, 7'd0, 7'd0, 2'd0, 2'd0, 11'h100));
        for (int i = 0; i < 16; i++) wr_op(13'h0001, 32'h100 + i);
        wr_op(13'h0001, 32'hDEAD);
        rd_exp(13'h0841, 32'h0000101C, "R3");
        rd_exp(13'h0841, 32'h0000100C, "R5");
        for (int i = 0; i < 5; i++) rd_exp(13'h0001, 32'h100 + i, "R2");
        for (int i = 0; i < 5; i++) wr_op(13'h0001, 32'h200 + i);
        rd_exp(13'h0841, 32'h0000100C, "R3");
        for (int i = 5; i < 16; i++) rd_exp(13'h0001, 32'h100 + i, "R2");
        for (int i = 0; i < 5; i++) rd_exp(13'h0001, 32'h200 + i, "R2");
        rd_exp(13'h1100, 32'h00000200, "R2");

        // R4 R5 underflow
        rd_exp(13'h0001, 32'h0, "R4");
        rd_exp(13'h0841, 32'h00000023, "R4");
        rd_exp(13'h0841, 32'h00000003, "R5");

        // R6 four-word entries, 32-word buffer
        wr_op(13'h0802, mkcfg(2'd0, 1'b0, 7'd2, 7'd1, 2'd2, 2'd1, 11'h200));
        for (int i = 0; i < 4; i++) wr_op(13'h0002, i);
        rd_exp(13'h0842, 32'h00000402, "R6");
        for (int i = 0; i < 4; i++) wr_op(13'h0002, i);
        rd_exp(13'h0842, 32'h00000800, "R6");
        for (int i = 0; i < 16; i++) wr_op(13'h0002, i);
        rd_exp(13'h0842, 32'h00001804, "R6");

        // R9 R11 R7 flag vector and low interrupt
        chk(flag_lo == 32'h4, "R9", flag_lo, 32'h4);
        wr_op(13'h0803, mkcfg(2'd0, 1'b0, 7'd0, 7'd0, 2'd0, 2'd0, 11'h300));
        wr_op(13'h0003, 32'h33);
        chk(flag_lo == 32'hC, "R9", flag_lo, 32'hC);
        chk(irq_lo == 1'b0, "R11", {31'b0, irq_lo}, 32'h0);
        wr_op(13'h0803, mkcfg(2'd0, 1'b1, 7'd0, 7'd0, 2'd0, 2'd0, 11'h300));
        rd_exp(13'h0843, 32'h00000003, "R7");
        chk(flag_lo == 32'h4, "R7", flag_lo, 32'h4);
        chk(irq_lo == 1'b0, "R11", {31'b0, irq_lo}, 32'h0);
        wr_op(13'h0003, 32'h34);
        chk(irq_lo == 1'b1, "R11", {31'b0, irq_lo}, 32'h1);

        // R10 R11 upper half
        chk({evt_hi, irq_hi} == 2'b00, "R10", {30'b0, evt_hi, irq_hi}, 32'h0);
        wr_op(13'h0828, mkcfg(2'd3, 1'b0, 7'd0, 7'd0, 2'd0, 2'd0, 11'h400));
        chk({evt_hi, irq_hi} == 2'b10, "R10", {30'b0, evt_hi, irq_hi}, 32'h2);
        wr_op(13'h0828, mkcfg(2'd3, 1'b1, 7'd0, 7'd0, 2'd0, 2'd0, 11'h400));
        chk({evt_hi, irq_hi} == 2'b11, "R11", {30'b0, evt_hi, irq_hi}, 32'h3);
        wr_op(13'h0028, 32'h40);
        chk({evt_hi, irq_hi} == 2'b00, "R10", {30'b0, evt_hi, irq_hi}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule